// File: doc/BRIEF.md
# Program Sequencer with Return Stack

This block sequences instruction fetch for a small microcontroller core. It keeps a 13-bit program counter and an eight-entry hardware stack of return addresses. Each clock cycle it applies one action: a reset, an interrupt entry, or an instruction-class command from the decoder. The commands are advance, jump, call, return, return-from-interrupt and return-with-literal. The updated counter is presented as the fetch address. Before it leaves the block, that address is masked to the size of the program memory actually fitted.

A branch target is built from an 11-bit literal and two page-select bits. This divides the 8K-word space into four pages of 2K words. Calls and interrupt entries save the address that follows the current one. All three return kinds restore the most recent saved entry. The stack has no guard against overflow or underflow: it simply wraps around.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the counter is set to 0000h and the stack is emptied, with all eight entries cleared to zero. After that edge `fetch_addr` reads 0000h.
- R2: With command code 0 (advance), or either unused code 6 or 7, the counter increases by one per cycle. It wraps from 1FFFh to 0000h.
- R3: When `irq_take` is high (and `rst` is low), the counter loads 0004h and the current counter plus one is pushed. This holds whatever command code is present at the same time.
- R4: Command code 1 (jump) loads the counter with `{page_sel, lit_tgt}`, with `page_sel` in bits 12:11. The stack is left unchanged.
- R5: Command code 2 (call) loads the same target as a jump and pushes the current counter plus one.
- R6: Command codes 3 (return), 4 (return from interrupt) and 5 (return with literal) each pop the stack. The counter takes the popped entry.
- R7: Up to eight nested pushes are returned in last-in, first-out order.
- R8: The stack is circular. A ninth push overwrites the oldest entry. A pop with no entry pushed since reset yields the entry the pointer wraps onto, which is zero.
- R9: `fetch_addr` equals the counter with every bit at or above position `IMPL_AW` forced to zero. For a 4K-word build (`IMPL_AW` = 12), addresses in pages 2 and 3 therefore fold onto pages 0 and 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| irq_take | input | 1 | Interrupt accepted this cycle |
| op_code | input | 3 | Instruction-class command (see R2 to R6) |
| lit_tgt | input | 11 | Literal branch target, low bits |
| page_sel | input | 2 | Page-select bits, placed in bits 12:11 of a target |
| fetch_addr | output | 13 | Fetch address, folded to implemented size |

## Verification
Two instances run side by side, one built with 8K words and one with 4K words. The same stimulus therefore separates masking errors from counter errors. A sweep covers every page and literal pairing with a jump. This exposes any swapped or misplaced target bit, and the 4K copy shows which pages fold. Call chains of depth eight, nine and ten, unwound with a mix of the three return codes, separate correct LIFO order from overwrite-of-oldest and pointer-wrap behaviour. Interrupts raised together with each command code show that interrupt entry wins. Advancing across 1FFFh, and popping straight after reset, probe the wrap boundaries.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int PC_W   = 13;
    localparam int LIT_W  = 11;
    localparam int PAGE_W = PC_W - LIT_W;

    typedef logic [PC_W-1:0] pc_t;

    localparam pc_t RESET_VEC = 13'h0000;
    localparam pc_t IRQ_VEC   = 13'h0004;

    typedef enum logic [2:0] {
        OP_NEXT  = 3'd0,
        OP_JUMP  = 3'd1,
        OP_CALL  = 3'd2,
        OP_RET   = 3'd3,
        OP_RETI  = 3'd4,
        OP_RETLW = 3'd5
    } seq_op_e;

    typedef struct packed {
        logic push;
        logic pop;
        pc_t  push_val;
    } stk_req_t;

    function automatic pc_t branch_target(logic [PAGE_W-1:0] page, logic [LIT_W-1:0] lit);
        return {page, lit};
    endfunction

    function automatic logic is_return(logic [2:0] code);
        return (code == OP_RET) || (code == OP_RETI) || (code == OP_RETLW);
    endfunction

endpackage

// File: rtl/pc_next_sel.sv
module pc_next_sel
    import pcseq_pkg::*;
(
    input  logic              irq_take,
    input  logic [2:0]        op_code,
    input  logic [LIT_W-1:0]  lit_tgt,
    input  logic [PAGE_W-1:0] page_sel,
    input  pc_t               pc_cur,
    input  pc_t               stk_top,
    output pc_t               pc_nxt,
    output stk_req_t          stk_req
);
    pc_t pc_inc;
    pc_t tgt;

    assign pc_inc = pc_cur + 1'b1;
    assign tgt    = branch_target(page_sel, lit_tgt);

    always_comb begin
        pc_nxt           = pc_inc;
        stk_req.push     = 1'b0;
        stk_req.pop      = 1'b0;
        stk_req.push_val = pc_inc;
        if (irq_take) begin
            pc_nxt       = IRQ_VEC;
            stk_req.push = 1'b1;
        end else begin
            case (op_code)
                OP_JUMP: pc_nxt = tgt;
                OP_CALL: begin
                    pc_nxt       = tgt;
                    stk_req.push = 1'b1;
                end
                OP_RET, OP_RETI, OP_RETLW: begin
                    pc_nxt      = stk_top;
                    stk_req.pop = 1'b1;
                end
                default: pc_nxt = pc_inc;
            endcase
        end
    end

endmodule

// File: rtl/ret_stack.sv
module ret_stack
    import pcseq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  stk_req_t req,
    output pc_t      top
);
    localparam int SP_W = $clog2(DEPTH);

    pc_t             mem [DEPTH];
    logic [SP_W-1:0] sp_q;
    logic [SP_W-1:0] sp_dec;

    assign sp_dec = sp_q - 1'b1;
    assign top    = mem[sp_dec];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (req.push) begin
            mem[sp_q] <= req.push_val;
            sp_q      <= sp_q + 1'b1;
        end else if (req.pop) begin
            sp_q <= sp_dec;
        end
    end

    // R8: pointer advances modulo DEPTH on a push
    a_r8_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
        req.push |=> sp_q == $past(sp_q) + 1'b1);

    // R6: pointer retreats on a pop
    a_r6_ptr_pop: assert property (@(posedge clk) disable iff (rst)
        (req.pop && !req.push) |=> sp_q == $past(sp_q) - 1'b1);

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int IMPL_AW = 13,
    parameter int DEPTH   = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        irq_take,
    input  logic [2:0]  op_code,
    input  logic [10:0] lit_tgt,
    input  logic [1:0]  page_sel,
    output logic [12:0] fetch_addr
);
    localparam pc_t ADDR_MASK = pc_t'((64'd1 << IMPL_AW) - 64'd1);

    pc_t      pc_q;
    pc_t      pc_nxt;
    pc_t      stk_top;
    stk_req_t stk_req;

    pc_next_sel u_sel (
        .irq_take (irq_take),
        .op_code  (op_code),
        .lit_tgt  (lit_tgt),
        .page_sel (page_sel),
        .pc_cur   (pc_q),
        .stk_top  (stk_top),
        .pc_nxt   (pc_nxt),
        .stk_req  (stk_req)
    );

    ret_stack #(.DEPTH(DEPTH)) u_stk (
        .clk (clk),
        .rst (rst),
        .req (stk_req),
        .top (stk_top)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_VEC;
        else     pc_q <= pc_nxt;
    end

    assign fetch_addr = pc_q & ADDR_MASK;

    logic call_now;
    logic ret_now;
    assign call_now = !rst && !irq_take && (op_code == OP_CALL);
    assign ret_now  = !rst && !irq_take && is_return(op_code);

    // R3: interrupt entry wins and lands on the vector
    a_r3_irq_vector: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> pc_q == IRQ_VEC);

    // R2: advance adds one
    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        (!irq_take && op_code == OP_NEXT) |=> pc_q == $past(pc_q) + 1'b1);

    // R4: jump target placement
    a_r4_jump_target: assert property (@(posedge clk) disable iff (rst)
        (!irq_take && op_code == OP_JUMP) |=> pc_q == {$past(page_sel), $past(lit_tgt)});

    // R7: a return right after a call comes back past the call site
    a_r7_call_return: assert property (@(posedge clk) disable iff (rst)
        (ret_now && $past(call_now)) |=> pc_q == $past(pc_q, 2) + 1'b1);

endmodule

// File: tb/sim_pc_sequencer.sv
`timescale 1ns/1ps
module sim_pc_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_take = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [10:0] lit_tgt = '0;
    logic [1:0]  page_sel = '0;
    logic [12:0] fa8, fa4;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [12:0] m_pc;
    logic [12:0] m_stk [8];
    int          m_sp;

    always #2 clk = ~clk;

    pc_sequencer #(.IMPL_AW(13), .DEPTH(8)) u0 (
        .clk(clk), .rst(rst), .irq_take(irq_take), .op_code(op_code),
        .lit_tgt(lit_tgt), .page_sel(page_sel), .fetch_addr(fa8));

    pc_sequencer #(.IMPL_AW(12), .DEPTH(8)) u1 (
        .clk(clk), .rst(rst), .irq_take(irq_take), .op_code(op_code),
        .lit_tgt(lit_tgt), .page_sel(page_sel), .fetch_addr(fa4));

    task automatic chk(string req, logic [12:0] act, logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_step(bit r, bit irq, logic [2:0] op, logic [10:0] lit, logic [1:0] pg);
        logic [12:0] inc;
        inc = m_pc + 13'd1;
        if (r) begin
            m_pc = '0;
            m_sp = 0;
            for (int i = 0; i < 8; i++) m_stk[i] = '0;
        end else if (irq) begin
            m_stk[m_sp] = inc; m_sp = (m_sp + 1) % 8; m_pc = 13'h0004;
        end else if (op == 3'd1) begin
            m_pc = {pg, lit};
        end else if (op == 3'd2) begin
            m_stk[m_sp] = inc; m_sp = (m_sp + 1) % 8; m_pc = {pg, lit};
        end else if (op >= 3'd3 && op <= 3'd5) begin
            m_sp = (m_sp + 7) % 8; m_pc = m_stk[m_sp];
        end else begin
            m_pc = inc;
        end
    endtask

    task automatic step(string req, bit r, bit irq, logic [2:0] op, logic [10:0] lit, logic [1:0] pg);
        rst = r; irq_take = irq; op_code = op; lit_tgt = lit; page_sel = pg;
        @(posedge clk);
        model_step(r, irq, op, lit, pg);
        @(negedge clk);
        chk(req, fa8, m_pc);
        chk({req, "/R9"}, fa4, m_pc & 13'h0FFF);
    endtask

    initial begin
        m_pc = '0; m_sp = 0;
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
        @(negedge clk);
        step("R1", 1'b1, 1'b0, 3'd0, '0, '0);
        step("R1", 1'b1, 1'b0, 3'd2, 11'h3A, 2'd3);
        // R2: advance, plus unused codes
        for (int i = 0; i < 6; i++) step("R2", 1'b0, 1'b0, 3'd0, 11'h7FF, 2'd3);
        step("R2", 1'b0, 1'b0, 3'd6, '0, '0);
        step("R2", 1'b0, 1'b0, 3'd7, '0, '0);
        // R2: wrap across 1FFFh
        step("R4", 1'b0, 1'b0, 3'd1, 11'h7FA, 2'd3);
        for (int i = 0; i < 10; i++) step("R2", 1'b0, 1'b0, 3'd0, '0, '0);
        // R4 / R9: every page and literal
        for (int p = 0; p < 4; p++)
            for (int l = 0; l < 2048; l++)
                step("R4", 1'b0, 1'b0, 3'd1, 11'(l), 2'(p));
        // R5 / R6 / R7: eight nested calls, mixed return codes
        for (int d = 0; d < 8; d++) begin
            step("R5", 1'b0, 1'b0, 3'd2, 11'(d * 37 + 5), 2'(d));
            step("R2", 1'b0, 1'b0, 3'd0, '0, '0);
        end
        for (int d = 0; d < 8; d++) step("R7", 1'b0, 1'b0, 3'(3 + d % 3), '0, '0);
        // R8: ten calls overwrite the two oldest, then unwind ten
        for (int d = 0; d < 10; d++) step("R8", 1'b0, 1'b0, 3'd2, 11'(d * 101), 2'(d + 1));
        for (int d = 0; d < 10; d++) step("R8", 1'b0, 1'b0, 3'(3 + d % 3), '0, '0);
        // R3: interrupt beside every code, then return from interrupt
        for (int c = 0; c < 8; c++) begin
            step("R4", 1'b0, 1'b0, 3'd1, 11'(c * 200 + 9), 2'(c));
            step("R3", 1'b0, 1'b1, 3'(c), 11'h155, 2'd2);
            step("R6", 1'b0, 1'b0, 3'd4, '0, '0);
        end
        // R8: pop right after reset yields zero
        step("R1", 1'b1, 1'b0, 3'd0, '0, '0);
        step("R2", 1'b0, 1'b0, 3'd0, '0, '0);
        step("R8", 1'b0, 1'b0, 3'd3, '0, '0);
        step("R8", 1'b0, 1'b0, 3'd5, '0, '0);
        step("R2", 1'b0, 1'b0, 3'd0, '0, '0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule